// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block keeps the two fault-reporting registers of a table-walking memory management unit: a status word that describes the most recent translation or permission fault, and an address word that holds the virtual address that faulted. The walker presents a one-cycle fault strobe together with a 3-bit access index, a fault code that already carries the walk level and the fault type, and the faulting address. The unit folds these into the status word. If an earlier fault was never read by software, the old contents are first replaced by an overflow marker.

On the same strobe the unit decides whether to request a trap. A trap is requested only when traps are enabled and the no-fault mode is off. The request carries a select bit that tells an instruction-fetch fault from a data-access fault. Software reads both registers through a small registered read port. A read of the status word clears it.

Top module: `fsc_capture`

## Requirements
- R1: After reset, both the status word and the address word read as zero, and `trap_req` is low.
- R2: A fault on an empty status word, with no status read in that cycle, sets the status word to (access index << 5) | (code & mask) | 2. The mask keeps the level in bits [9:8] and the type in bits [4:2]. Bit 1 marks the fault address as valid, and bit 0 is left clear.
- R3: A fault that arrives while the status word is nonzero and no status read is in progress first replaces the old word with 1, then ORs in the new fields. Bit 0 set marks overflow, and the old field bits are lost.
- R4: Every fault strobe loads `flt_addr` into the address word, whether or not a trap is raised.
- R5: A read with `rd_sel`=0 returns the status word on `rd_data` in the cycle after `rd_en` and clears the status word to zero.
- R6: When a status read and a fault occur in the same cycle, the read returns the old value. The status word then holds only the new fields, with bit 0 clear.
- R7: With `nofault_mode`=1 or `trap_en`=0, a fault raises no trap but is still recorded in both registers.
- R8: Otherwise a fault raises `trap_req` in the next cycle. `trap_inst` then equals access-index bit 1, the instruction-fetch flag: 1 means an instruction-access trap and 0 means a data-access trap. Access-index bit 2 is the write flag and bit 0 is the supervisor flag.
- R9: A read with `rd_sel`=1 returns the address word one cycle later and changes neither register.
- R10: `trap_req` is a pulse that lasts one cycle for each qualifying fault strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_stb | input | 1 | Fault strobe, one cycle per fault |
| flt_aidx | input | 3 | Access index: bit2 write, bit1 instruction fetch, bit0 supervisor |
| flt_code | input | 10 | Packed fault code: level [9:8], type [4:2] |
| flt_addr | input | 32 | Faulting virtual address |
| nofault_mode | input | 1 | Suppresses trap requests |
| trap_en | input | 1 | Trap enable |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the address word |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| trap_req | output | 1 | One-cycle trap request |
| trap_inst | output | 1 | Trap kind: 1 instruction access, 0 data access |

## Verification
The bench goes after the sticky overflow path. A design that ORs onto the old word instead of replacing it would leak the earlier access-index bits into the result, and one that never sets bit 0 would hide a lost fault. The read/fault collision is driven directly: a design that lets the clear win would drop the fault, and one that applies the overflow rule would wrongly set bit 0. Trap suppression under each gating input is checked by confirming that the fault was still recorded. The trap select is checked for both fetch and data accesses, and the request is checked to fall after a single cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int AIDX_W     = 3;
  localparam int AIDX_SHIFT = 5;
  localparam int IFETCH_BIT = 1;
  localparam int LVL_LSB    = 8;
  localparam int LVL_W      = 2;
  localparam int TYPE_LSB   = 2;
  localparam int TYPE_W     = 3;
  localparam int CODE_W     = LVL_LSB + LVL_W;
  localparam logic [CODE_W-1:0] CODE_MASK =
      CODE_W'(((1 << LVL_W) - 1) << LVL_LSB) | CODE_W'(((1 << TYPE_W) - 1) << TYPE_LSB);
  localparam int VALID_BIT  = 1;
  localparam int OVF_BIT    = 0;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ADDR = 1'b1} rd_sel_e;
  typedef enum logic {TRAP_DATA = 1'b0, TRAP_INST = 1'b1} trap_kind_e;
endpackage

// File: rtl/fsc_status_reg.sv
module fsc_status_reg
  import fsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_i,
  input  logic [AIDX_W-1:0] aidx_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] VALID_MASK = DATA_W'(1) << VALID_BIT;
  localparam logic [DATA_W-1:0] OVF_MASK   = DATA_W'(1) << OVF_BIT;

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] fields;
  logic [DATA_W-1:0] base;

  always_comb begin
    fields = (DATA_W'(aidx_i) << AIDX_SHIFT) | DATA_W'(code_i & CODE_MASK) | VALID_MASK;
    // an unread word collapses to the overflow marker; a read this cycle empties it first
    base   = (stat_q != '0 && !clr_i) ? OVF_MASK : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= '0;
    else if (fault_i) stat_q <= base | fields;
    else if (clr_i)   stat_q <= '0;
  end

  assign stat_o = stat_q;

  // R3: unread fault plus new fault gives overflow
  a_r3_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (fault_i && stat_q != '0 && !clr_i) |=> stat_q[OVF_BIT]);
  // R2: every capture marks the address valid
  a_r2_valid_flag: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> stat_q[VALID_BIT]);
  // R5: a read without a fault empties the word
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !fault_i) |=> stat_q == '0);
  // R6: collision never flags overflow
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (clr_i && fault_i) |=> !stat_q[OVF_BIT]);
endmodule

// File: rtl/fsc_addr_reg.sv
module fsc_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [DATA_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;

  // R4: address follows each strobe
  a_r4_addr_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_q == $past(addr_i));
  // R9: no strobe, no change
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_q));
endmodule

// File: rtl/fsc_trap_sel.sv
module fsc_trap_sel
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic ifetch_i,
  input  logic nofault_i,
  input  logic enable_i,
  output logic req_o,
  output logic inst_o
);
  logic       req_q;
  trap_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      kind_q <= TRAP_DATA;
    end else begin
      req_q <= fault_i && enable_i && !nofault_i;
      if (fault_i) kind_q <= ifetch_i ? TRAP_INST : TRAP_DATA;
    end
  end

  assign req_o  = req_q;
  assign inst_o = kind_q;

  // R7: gated faults stay quiet
  a_r7_suppress: assert property (@(posedge clk) disable iff (rst)
    (fault_i && (nofault_i || !enable_i)) |=> !req_o);
  // R8: qualifying fault gives the right kind of trap
  a_r8_trap_kind: assert property (@(posedge clk) disable iff (rst)
    (fault_i && enable_i && !nofault_i) |=> (req_o && inst_o == $past(ifetch_i)));
  // R10: no strobe, no request
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    !fault_i |=> !req_o);
endmodule

// File: rtl/fsc_capture.sv
module fsc_capture
  import fsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flt_stb,
  input  logic [AIDX_W-1:0]    flt_aidx,
  input  logic [CODE_W-1:0]    flt_code,
  input  logic [DATA_W-1:0]    flt_addr,
  input  logic                 nofault_mode,
  input  logic                 trap_en,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 trap_req,
  output logic                 trap_inst
);
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] addr_w;
  logic              stat_rd;
  logic [DATA_W-1:0] rd_q;

  assign stat_rd = rd_en && (rd_sel == SEL_STATUS);

  fsc_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .fault_i(flt_stb), .aidx_i(flt_aidx),
    .code_i(flt_code), .clr_i(stat_rd), .stat_o(stat_w));

  fsc_addr_reg #(.DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .load_i(flt_stb), .addr_i(flt_addr), .addr_o(addr_w));

  fsc_trap_sel u_trap (
    .clk(clk), .rst(rst), .fault_i(flt_stb), .ifetch_i(flt_aidx[IFETCH_BIT]),
    .nofault_i(nofault_mode), .enable_i(trap_en),
    .req_o(trap_req), .inst_o(trap_inst));

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= (rd_sel == SEL_STATUS) ? stat_w : addr_w;
  end

  assign rd_data = rd_q;

  // R5: status read returns the pre-clear value
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> rd_data == $past(stat_w));
endmodule

// File: tb/fsc_capture_test.sv
module fsc_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_stb = 1'b0;
  logic [2:0]  flt_aidx = '0;
  logic [9:0]  flt_code = '0;
  logic [31:0] flt_addr = '0;
  logic        nofault_mode = 1'b0;
  logic        trap_en = 1'b1;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        trap_req;
  logic        trap_inst;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fsc_capture uut (
    .clk(clk), .rst(rst), .flt_stb(flt_stb), .flt_aidx(flt_aidx),
    .flt_code(flt_code), .flt_addr(flt_addr), .nofault_mode(nofault_mode),
    .trap_en(trap_en), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .trap_req(trap_req), .trap_inst(trap_inst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fields(input logic [2:0] a, input logic [9:0] c);
    return ({29'd0, a} << 5) | {22'd0, c & 10'h31C} | 32'h2;
  endfunction

  // one cycle with optional fault and optional read; returns to idle at next negedge
  task automatic cycle(input logic f, input logic [2:0] a, input logic [9:0] c,
                       input logic [31:0] ad, input logic nf, input logic en,
                       input logic r, input logic s);
    flt_stb = f; flt_aidx = a; flt_code = c; flt_addr = ad;
    nofault_mode = nf; trap_en = en; rd_en = r; rd_sel = s;
    @(negedge clk);
    flt_stb = 1'b0; rd_en = 1'b0; nofault_mode = 1'b0; trap_en = 1'b1;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    cycle(1'b0, 3'd0, 10'd0, 32'd0, 1'b0, 1'b1, 1'b1, s);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 trap_req", {31'd0, trap_req}, 32'd0);
    rd(1'b1, v); check("R1 address", v, 32'd0);
    rd(1'b0, v); check("R1 status", v, 32'd0);
  endtask

  task automatic t_single_data();
    logic [31:0] v;
    cycle(1'b1, 3'b101, 10'h10C, 32'hDEADB000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 trap_req", {31'd0, trap_req}, 32'd1);
    check("R8 trap_inst data", {31'd0, trap_inst}, 32'd0);
    @(negedge clk);
    check("R10 pulse ends", {31'd0, trap_req}, 32'd0);
    rd(1'b1, v); check("R4 address", v, 32'hDEADB000);
    rd(1'b0, v); check("R2 status", v, fields(3'b101, 10'h10C));
    check("R2 value", v, 32'h000001AE);
    rd(1'b0, v); check("R5 cleared", v, 32'd0);
  endtask

  task automatic t_addr_read_no_side_effect();
    logic [31:0] v;
    cycle(1'b1, 3'b001, 10'h004, 32'h00001234, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(1'b1, v); check("R9 address", v, 32'h00001234);
    rd(1'b1, v); check("R9 address held", v, 32'h00001234);
    rd(1'b0, v); check("R9 status kept", v, fields(3'b001, 10'h004));
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    cycle(1'b1, 3'b010, 10'h004, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 3'b100, 10'h308, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(1'b1, v); check("R4 latest address", v, 32'h2000);
    rd(1'b0, v); check("R3 overflow", v, 32'h0000038B);
  endtask

  task automatic t_inst_trap();
    logic [31:0] v;
    cycle(1'b1, 3'b011, 10'h20C, 32'h4000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 trap_req inst", {31'd0, trap_req}, 32'd1);
    check("R8 trap_inst inst", {31'd0, trap_inst}, 32'd1);
    rd(1'b0, v);
  endtask

  task automatic t_suppress();
    logic [31:0] v;
    cycle(1'b1, 3'b011, 10'h104, 32'h5000, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 nofault no trap", {31'd0, trap_req}, 32'd0);
    rd(1'b0, v); check("R7 nofault recorded", v, fields(3'b011, 10'h104));
    cycle(1'b1, 3'b100, 10'h210, 32'h6000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 disabled no trap", {31'd0, trap_req}, 32'd0);
    rd(1'b1, v); check("R7 disabled address", v, 32'h6000);
    rd(1'b0, v); check("R7 disabled recorded", v, fields(3'b100, 10'h210));
  endtask

  task automatic t_collision();
    logic [31:0] v;
    cycle(1'b1, 3'b001, 10'h204, 32'h7000, 1'b0, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 3'b110, 10'h110, 32'h8000, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 read returns old", rd_data, 32'h00000226);
    rd(1'b0, v); check("R6 new fields only", v, 32'h000001D2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_data();
    t_addr_read_no_side_effect();
    t_overflow();
    t_inst_trap();
    t_suppress();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule